// File: doc/BRIEF.md
# Interleaved Dual-Bus Serializer

This block turns parallel pixel words into a serial bit stream, most significant stage first. Its parallel load word comes from a two-way selector. One leg is a live A bus. The other leg is a B bus held in a level-sensitive transparent latch. Because of the latch, the next word can be parked while the current word shifts out, and A and B words can be loaded alternately with no idle clocks between frames.

On a rising clock edge with the active-low parallel enable low, all stages load from the selected word. With the enable high, the edge shifts the register one place toward the output. The serial input fills the first stage, so several instances can be chained into a longer shifter.

An asynchronous active-low reset clears the register and the B latch.

Top module: `ilv_serializer`

## Requirements
- R1: While reset is low, serOut is 0. After reset, loading the B leg with the latch closed (latchEn = 0) gives an all-zero word.
- R2: On a rising edge with parEnN = 0, every stage takes the selected word. serOut then shows bit WIDTH-1 of that word.
- R3: On a rising edge with parEnN = 1, stage 0 takes serIn and each stage n takes the old stage n-1. serOut shows the old stage WIDTH-2. A word therefore leaves as bit WIDTH-1 down to bit 0, and serIn bits come out WIDTH edges after they enter.
- R4: With selB = 0 at the load edge, the register takes aBus.
- R5: With selB = 1 and latchEn = 1 at the load edge, the register takes the current bBus value (transparent latch).
- R6: With latchEn = 0, the latch holds its last word. Changes on bBus have no effect on a later B load.
- R7: The latch follows latchEn alone, regardless of the clock and parEnN. Opening it while a word shifts does not disturb the serial stream, and the captured word is used by the next B load.
- R8: When one instance's serOut drives a second instance's serIn, the second instance's serOut gives a 2*WIDTH-bit stream. The stream is the second word MSB first, then the first word MSB first.
- R9: If a B load is placed on the edge right after the last shift of an A word, the A and B frames leave back to back with no gap bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| parEnN | input | 1 | Low: load at the edge; high: shift |
| selB | input | 1 | Load source: 0 = A bus, 1 = B latch |
| latchEn | input | 1 | High: B latch transparent; low: hold |
| aBus | input | WIDTH | Direct parallel word |
| bBus | input | WIDTH | Latched parallel word |
| serIn | input | 1 | Serial input into stage 0 |
| serOut | output | 1 | Last stage, serial output |

## Verification
The assertions assume parEnN, selB, aBus and bBus are stable around each rising edge. They also assume latchEn is not pulsed high and low again entirely between two clock edges, because the hold check compares latch contents at consecutive edges. The stimulus changes every input just after a rising edge, and it holds each latch-open window across at least one edge. A separate scenario opens the latch between edges on purpose and checks its effect only at the ports.

// File: rtl/ilv_serializer_pkg.sv
package ilv_serializer_pkg;
  // Strobes sent from control to datapath, sampled at the rising edge
  typedef struct packed {
    logic loadWord;
    logic shiftWord;
    logic pickB;
  } strobe_t;
endpackage

// File: rtl/ilv_serializer_ctrl.sv
module ilv_serializer_ctrl
  import ilv_serializer_pkg::*;
(
  input  logic    parEnN,
  input  logic    selB,
  output strobe_t strobe
);
  // Pure decode: the controls act only when the datapath samples them at the clock edge
  always_comb begin
    strobe.loadWord  = ~parEnN;
    strobe.shiftWord = parEnN;
    strobe.pickB     = selB;
  end
endmodule

// File: rtl/ilv_serializer_dp.sv
module ilv_serializer_dp
  import ilv_serializer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             latchEn,
  input  logic [WIDTH-1:0] aBus,
  input  logic [WIDTH-1:0] bBus,
  input  logic             serIn,
  output logic             serOut
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] bHeld;
  logic [WIDTH-1:0] muxWord;
  logic [WIDTH-1:0] stages;
  logic [WIDTH-1:0] nextStages;

  // Level-sensitive B holding latch
  always_latch begin
    if (!rstN)        bHeld = '0;
    else if (latchEn) bHeld = bBus;
  end

  assign muxWord = strobe.pickB ? bHeld : aBus;

  // Per-stage next value: load word or shifted neighbour
  for (genvar i = 0; i < WIDTH; i++) begin : gStage
    if (i == 0) begin : gHead
      assign nextStages[i] = strobe.loadWord ? muxWord[i] : serIn;
    end else begin : gBody
      assign nextStages[i] = strobe.loadWord ? muxWord[i] : stages[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stages <= '0;
    else       stages <= nextStages;
  end

  assign serOut = stages[LAST];

  // R2: a load edge places the selected word into the register
  assert_load_word_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWord |=> stages == $past(muxWord));

  // R3: a shift edge moves every stage up and inserts serIn
  assert_shift_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftWord |=> (stages[LAST:1] == $past(stages[LAST-1:0]))
                         && (stages[0] == $past(serIn)));

  // R4: an A-side load takes the A bus
  assert_load_a_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadWord && !strobe.pickB) |=> stages == $past(aBus));

  // R5: a B-side load with the latch open takes the live B bus
  assert_load_b_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadWord && strobe.pickB && latchEn) |=> stages == $past(bBus));

  // R6: a closed latch keeps its word across edges
  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!latchEn && $past(!latchEn)) |-> bHeld == $past(bHeld));
endmodule

// File: rtl/ilv_serializer.sv
module ilv_serializer
  import ilv_serializer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             parEnN,
  input  logic             selB,
  input  logic             latchEn,
  input  logic [WIDTH-1:0] aBus,
  input  logic [WIDTH-1:0] bBus,
  input  logic             serIn,
  output logic             serOut
);
  strobe_t strobe;

  ilv_serializer_ctrl uCtrl (
    .parEnN (parEnN),
    .selB   (selB),
    .strobe (strobe)
  );

  ilv_serializer_dp #(.WIDTH(WIDTH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .latchEn (latchEn),
    .aBus    (aBus),
    .bBus    (bBus),
    .serIn   (serIn),
    .serOut  (serOut)
  );
endmodule

// File: tb/tb_ilv_serializer.sv
module tb_ilv_serializer;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic parEnN = 1'b1;
  logic selB = 1'b0;
  logic latchEn = 1'b0;
  logic [W-1:0] aBus = '0;
  logic [W-1:0] aBusHi = '0;
  logic [W-1:0] bBus = '0;
  logic serIn = 1'b0;
  logic serOut, serOutHi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ilv_serializer #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .parEnN(parEnN), .selB(selB), .latchEn(latchEn),
    .aBus(aBus), .bBus(bBus), .serIn(serIn), .serOut(serOut));

  // Second stage of the cascade, fed by the first instance's output
  ilv_serializer #(.WIDTH(W)) dut2 (
    .clk(clk), .rstN(rstN), .parEnN(parEnN), .selB(selB), .latchEn(latchEn),
    .aBus(aBusHi), .bBus(bBus), .serIn(serOut), .serOut(serOutHi));

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expectBit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Load on one edge, then shift W-1 times, checking MSB first
  task automatic loadAndDrain(input logic pickB, input logic [W-1:0] word, input string tag);
    parEnN = 1'b0; selB = pickB;
    tick();
    expectBit(serOut, word[W-1], tag);
    parEnN = 1'b1;
    for (int i = W-2; i >= 0; i--) begin
      tick();
      expectBit(serOut, word[i], tag);
    end
  endtask

  task automatic testReset();
    expectBit(serOut, 1'b0, "R1 serOut in reset");
    #5 rstN = 1'b1;
    tick();
    latchEn = 1'b0;
    loadAndDrain(1'b1, '0, "R1 latch cleared");
  endtask

  task automatic testLoadA();
    aBus = 8'hA5; bBus = 8'hFF;
    loadAndDrain(1'b0, 8'hA5, "R2 R4 load A");
    aBus = 8'h3E;
    loadAndDrain(1'b0, 8'h3E, "R2 R4 load A second");
  endtask

  task automatic testTransparent();
    latchEn = 1'b1; bBus = 8'h3C; aBus = 8'hFF;
    loadAndDrain(1'b1, 8'h3C, "R5 transparent B");
    latchEn = 1'b0;
  endtask

  task automatic testHeld();
    bBus = 8'h5A; #3 latchEn = 1'b1; #3 latchEn = 1'b0; #1 bBus = 8'hC3;
    tick();
    loadAndDrain(1'b1, 8'h5A, "R6 held B");
  endtask

  task automatic testSerialIn();
    logic [W-1:0] pat = 8'hB4;
    aBus = '0;
    loadAndDrain(1'b0, '0, "R3 clear");
    for (int i = W-1; i >= 0; i--) begin
      serIn = pat[i];
      tick();
      expectBit(serOut, (i == 0) ? pat[W-1] : 1'b0, "R3 fill");
    end
    serIn = 1'b0;
    for (int i = W-2; i >= 0; i--) begin
      tick();
      expectBit(serOut, pat[i], "R3 serial out");
    end
  endtask

  task automatic testIndependence();
    logic [W-1:0] word = 8'h96;
    aBus = word; bBus = 8'h71;
    parEnN = 1'b0; selB = 1'b0;
    tick();
    expectBit(serOut, word[W-1], "R7 stream");
    parEnN = 1'b1;
    for (int i = W-2; i >= 0; i--) begin
      if (i == 4) latchEn = 1'b1;
      if (i == 2) begin latchEn = 1'b0; #1 bBus = 8'h0F; end
      tick();
      expectBit(serOut, word[i], "R7 stream undisturbed");
    end
    loadAndDrain(1'b1, 8'h71, "R7 captured B");
  endtask

  task automatic testBackToBack();
    logic [2*W-1:0] frame = {8'hD2, 8'h4B};
    bBus = 8'h4B; latchEn = 1'b1;
    tick();
    latchEn = 1'b0; bBus = 8'h00; aBus = 8'hD2;
    parEnN = 1'b0; selB = 1'b0;
    tick();
    expectBit(serOut, frame[2*W-1], "R9 frame");
    parEnN = 1'b1;
    for (int i = 2*W-2; i >= 0; i--) begin
      if (i == W-1) begin parEnN = 1'b0; selB = 1'b1; end
      else parEnN = 1'b1;
      tick();
      expectBit(serOut, frame[i], "R9 back to back");
    end
    parEnN = 1'b1;
  endtask

  task automatic testCascade();
    logic [2*W-1:0] stream = {8'hE1, 8'h6D};
    aBus = 8'h6D; aBusHi = 8'hE1; serIn = 1'b0;
    parEnN = 1'b0; selB = 1'b0;
    tick();
    expectBit(serOutHi, stream[2*W-1], "R8 cascade");
    parEnN = 1'b1;
    for (int i = 2*W-2; i >= 0; i--) begin
      tick();
      expectBit(serOutHi, stream[i], "R8 cascade");
    end
  endtask

  initial begin
    #3;
    testReset();
    testLoadA();
    testTransparent();
    testHeld();
    testSerialIn();
    testIndependence();
    testBackToBack();
    testCascade();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule